// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block copies a contiguous run of bytes out of a one-time-programmable fuse array and presents them as a byte stream. A command gives a start address and a byte count. The sequencer first powers up the fuse domain in a fixed order: a write-mask unlock, two power-switch stages separated by a settle delay, and release of the isolation between the fuse domain and the core. It then performs one handshaked read per address in ascending order. When the last byte is read, or when a read times out, it powers the domain down in the reverse order.

Each read drives the address with a request line high and waits for the fuse macro to raise ready. The low byte of the macro's returned word is captured and emitted with a one-cycle strobe. If ready does not arrive within a parameterised number of cycles, the operation is abandoned with a busy error and no further bytes are produced. The domain is still powered down. A single done pulse marks the end of every command, including failed ones. A zero-length command finishes at once and does not touch the power controls or the macro.

Top module: `fuse_rd_seq`

## Requirements
- R1: Power-up raises `pwr_unlock`, then `pwr_sw1`, then `pwr_sw2`, then drops `pwr_iso` (1 = isolated). Each step falls in its own cycle, and `pwr_sw2` rises exactly SETTLE_CYC cycles after `pwr_sw1`.
- R2: Power-down raises `pwr_iso`, then drops `pwr_sw2`, then `pwr_sw1`, then `pwr_unlock`. Each step falls in its own cycle, and `pwr_sw1` falls exactly SETTLE_CYC cycles after `pwr_sw2`.
- R3: `fuse_req` is high only while the domain is powered (`pwr_sw2`=1, `pwr_iso`=0). Once raised, it stays high with a stable `fuse_addr` until `fuse_rdy` is seen or the timeout fires.
- R4: Each read emits exactly one byte. That byte equals bits [7:0] of `fuse_word` at the cycle `fuse_rdy` is seen, and `out_valid` is high for one cycle per byte. The upper word bits have no effect.
- R5: Reads go to addresses cmd_addr, cmd_addr+1, …, cmd_addr+cmd_len-1, in increasing order, one request each.
- R6: A read is accepted only if `fuse_rdy` is seen within TIMEOUT_CYC cycles of `fuse_req` rising. Otherwise the command ends with `err_busy`=1, no further requests or bytes, and a full power-down.
- R7: A command with `cmd_len`=0 gives `done` the cycle after the start cycle, with `err_busy`=0, no power-control change and no fuse request.
- R8: `done` is a one-cycle pulse, raised the cycle after `pwr_unlock` falls. `err_busy` is valid with it and holds until the next accepted command.
- R9: `cmd_start` while `busy`=1 is ignored. The running command keeps its addresses, length and single done pulse.
- R10: After reset, `pwr_iso`=1, all other power outputs are 0, and `busy`, `fuse_req`, `out_valid`, `done` and `err_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start a command (taken only when idle) |
| cmd_addr | input | ADDR_W | First fuse address |
| cmd_len | input | LEN_W | Number of bytes to read |
| busy | output | 1 | Command in progress |
| fuse_addr | output | ADDR_W | Address to the fuse macro |
| fuse_req | output | 1 | Read request; low means ready flag cleared |
| fuse_rdy | input | 1 | Macro ready, data valid |
| fuse_word | input | WORD_W | Macro control/data word, data in bits [7:0] |
| pwr_unlock | output | 1 | Write-mask unlock for power controls |
| pwr_sw1 | output | 1 | Power switch stage 1 |
| pwr_sw2 | output | 1 | Power switch stage 2 |
| pwr_iso | output | 1 | Fuse-to-core isolation, 1 = isolated |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Output byte |
| done | output | 1 | End-of-command pulse |
| err_busy | output | 1 | Last command ended by read timeout |

## Verification
The embedded properties check the following on every cycle:
- the nesting of the power controls (stage 2 only under stage 1, stage 1 only under unlock, isolation released only with stage 2 on);
- one power-control change per cycle;
- requests only into a powered domain, with the address held while a request is pending;
- single-cycle strobes and done pulses;
- no byte on a timeout;
- the immediate completion of zero-length commands.

The directed scenarios cover what a property cannot see, by recording the power-control sequence and address trace of each command:
- the exact settle gaps;
- the full order of the power-up and power-down steps;
- byte values against the addresses;
- the accept/reject boundary at the timeout limit;
- abort partway through a range;
- a start command arriving while busy being ignored.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

    // Power-domain control bundle; iso = 1 means fuse domain isolated from core.
    typedef struct packed {
        logic unlock;
        logic sw1;
        logic sw2;
        logic iso;
    } pwr_ctl_t;

    localparam pwr_ctl_t PWR_SAFE = '{unlock: 1'b0, sw1: 1'b0, sw2: 1'b0, iso: 1'b1};

    // Power controller phases; each names the step it performs on leaving.
    typedef enum logic [3:0] {
        PW_OFF,        // idle, on up request raise unlock
        PW_UP_SW1,     // raise switch stage 1
        PW_UP_SETTLE,  // count settle cycles, then raise stage 2
        PW_UP_ISO,     // release isolation
        PW_ON,         // domain usable, on down request re-isolate
        PW_DN_SW2,     // drop switch stage 2
        PW_DN_SETTLE,  // count settle cycles, then drop stage 1
        PW_DN_UNLOCK   // drop unlock, report completion
    } pwr_phase_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_REQ,
        RD_RELEASE
    } rd_state_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_POWER_UP,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_POWER_DN
    } seq_state_e;

endpackage

// File: rtl/fuse_pwr_ctrl.sv
module fuse_pwr_ctrl
    import fuse_rd_pkg::*;
#(
    parameter int SETTLE_CYC = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     up_req,
    input  logic     dn_req,
    output pwr_ctl_t ctl,
    output logic     pwr_on,
    output logic     dn_done
);

    localparam int SET_W = $clog2(SETTLE_CYC + 1);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

    pwr_phase_e       phase;
    logic [SET_W-1:0] settle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PW_OFF;
            ctl        <= PWR_SAFE;
            settle_cnt <= '0;
            dn_done    <= 1'b0;
        end else begin
            dn_done <= 1'b0;
            case (phase)
                PW_OFF: begin
                    if (up_req) begin
                        ctl.unlock <= 1'b1;
                        phase      <= PW_UP_SW1;
                    end
                end
                PW_UP_SW1: begin
                    ctl.sw1    <= 1'b1;
                    settle_cnt <= '0;
                    phase      <= PW_UP_SETTLE;
                end
                PW_UP_SETTLE: begin
                    if (settle_cnt == SET_LAST) begin
                        ctl.sw2 <= 1'b1;
                        phase   <= PW_UP_ISO;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                PW_UP_ISO: begin
                    ctl.iso <= 1'b0;
                    phase   <= PW_ON;
                end
                PW_ON: begin
                    if (dn_req) begin
                        ctl.iso <= 1'b1;
                        phase   <= PW_DN_SW2;
                    end
                end
                PW_DN_SW2: begin
                    ctl.sw2    <= 1'b0;
                    settle_cnt <= '0;
                    phase      <= PW_DN_SETTLE;
                end
                PW_DN_SETTLE: begin
                    if (settle_cnt == SET_LAST) begin
                        ctl.sw1 <= 1'b0;
                        phase   <= PW_DN_UNLOCK;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                PW_DN_UNLOCK: begin
                    ctl.unlock <= 1'b0;
                    dn_done    <= 1'b1;
                    phase      <= PW_OFF;
                end
                default: phase <= PW_OFF;
            endcase
        end
    end

    assign pwr_on = (phase == PW_ON);

    AST_SW2_UNDER_SW1: assert property (@(posedge clk) disable iff (rst)
        ctl.sw2 |-> ctl.sw1); // R1
    AST_SW1_UNDER_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        ctl.sw1 |-> ctl.unlock); // R1
    AST_ISO_OPEN_POWERED: assert property (@(posedge clk) disable iff (rst)
        !ctl.iso |-> ctl.sw2); // R1
    AST_ONE_STEP_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(ctl ^ $past(ctl)) <= 1)); // R2
    AST_DONE_AFTER_UNLOCK_DROP: assert property (@(posedge clk) disable iff (rst)
        dn_done |-> (!ctl.unlock && $past(ctl.unlock))); // R2

endmodule

// File: rtl/fuse_byte_reader.sv
module fuse_byte_reader
    import fuse_rd_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int WORD_W      = 32,
    parameter int TIMEOUT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] go_addr,
    output logic [ADDR_W-1:0] fuse_addr,
    output logic              fuse_req,
    input  logic              fuse_rdy,
    input  logic [WORD_W-1:0] fuse_word,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              byte_ok,
    output logic              timeout
);

    localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYC - 1);

    rd_state_e        st;
    logic [TMO_W-1:0] wait_cnt;
    logic             unused_word_hi;

    assign unused_word_hi = ^fuse_word[WORD_W-1:8];

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RD_IDLE;
            fuse_addr <= '0;
            fuse_req  <= 1'b0;
            wait_cnt  <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            byte_ok   <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            byte_ok   <= 1'b0;
            timeout   <= 1'b0;
            case (st)
                RD_IDLE: begin
                    if (go) begin
                        fuse_addr <= go_addr;
                        fuse_req  <= 1'b1;
                        wait_cnt  <= '0;
                        st        <= RD_REQ;
                    end
                end
                RD_REQ: begin
                    if (fuse_rdy) begin
                        fuse_req  <= 1'b0;
                        out_valid <= 1'b1;
                        out_data  <= fuse_word[7:0];
                        wait_cnt  <= '0;
                        st        <= RD_RELEASE;
                    end else if (wait_cnt == TMO_LAST) begin
                        fuse_req <= 1'b0;
                        timeout  <= 1'b1;
                        st       <= RD_IDLE;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                RD_RELEASE: begin
                    // macro must drop ready before the next address goes out
                    if (!fuse_rdy) begin
                        byte_ok <= 1'b1;
                        st      <= RD_IDLE;
                    end else if (wait_cnt == TMO_LAST) begin
                        timeout <= 1'b1;
                        st      <= RD_IDLE;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: st <= RD_IDLE;
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (fuse_req && !fuse_rdy) |=> (fuse_req || timeout)); // R3
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (fuse_req && $past(fuse_req)) |-> $stable(fuse_addr)); // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R4
    AST_NO_BYTE_ON_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (!out_valid && !byte_ok)); // R6

endmodule

// File: rtl/fuse_range_ctr.sv
module fuse_range_ctr #(
    parameter int ADDR_W = 11,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              is_last
);

    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            remain   <= load_len;
        end else if (step) begin
            cur_addr <= cur_addr + 1'b1;
            remain   <= remain - 1'b1;
        end
    end

    assign is_last = (remain == LEN_W'(1));

    AST_RANGE_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        step |-> (remain > LEN_W'(1))); // R5

endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int LEN_W       = 12,
    parameter int WORD_W      = 32,
    parameter int SETTLE_CYC  = 8,
    parameter int TIMEOUT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              busy,
    output logic [ADDR_W-1:0] fuse_addr,
    output logic              fuse_req,
    input  logic              fuse_rdy,
    input  logic [WORD_W-1:0] fuse_word,
    output logic              pwr_unlock,
    output logic              pwr_sw1,
    output logic              pwr_sw2,
    output logic              pwr_iso,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              done,
    output logic              err_busy
);

    seq_state_e        state;
    pwr_ctl_t          ctl;
    logic              pwr_on;
    logic              pwr_dn_done;
    logic              rd_go;
    logic              rd_byte_ok;
    logic              rd_timeout;
    logic              accept;
    logic              load;
    logic              step;
    logic              is_last;
    logic [ADDR_W-1:0] cur_addr;

    assign accept = (state == SQ_IDLE) && cmd_start;
    assign load   = accept && (cmd_len != '0);
    assign step   = (state == SQ_WAIT) && rd_byte_ok && !is_last;
    assign rd_go  = (state == SQ_ISSUE);
    assign busy   = (state != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            done     <= 1'b0;
            err_busy <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (accept) begin
                        err_busy <= 1'b0;
                        if (cmd_len == '0) done <= 1'b1;
                        else               state <= SQ_POWER_UP;
                    end
                end
                SQ_POWER_UP: if (pwr_on) state <= SQ_ISSUE;
                SQ_ISSUE:    state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (rd_timeout) begin
                        err_busy <= 1'b1;
                        state    <= SQ_POWER_DN;
                    end else if (rd_byte_ok) begin
                        state <= is_last ? SQ_POWER_DN : SQ_ISSUE;
                    end
                end
                SQ_POWER_DN: begin
                    if (pwr_dn_done) begin
                        done  <= 1'b1;
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    fuse_range_ctr #(
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W)
    ) i_range (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_addr(cmd_addr),
        .load_len (cmd_len),
        .step     (step),
        .cur_addr (cur_addr),
        .is_last  (is_last)
    );

    fuse_pwr_ctrl #(
        .SETTLE_CYC(SETTLE_CYC)
    ) i_pwr (
        .clk    (clk),
        .rst    (rst),
        .up_req (state == SQ_POWER_UP),
        .dn_req (state == SQ_POWER_DN),
        .ctl    (ctl),
        .pwr_on (pwr_on),
        .dn_done(pwr_dn_done)
    );

    fuse_byte_reader #(
        .ADDR_W     (ADDR_W),
        .WORD_W     (WORD_W),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) i_reader (
        .clk      (clk),
        .rst      (rst),
        .go       (rd_go),
        .go_addr  (cur_addr),
        .fuse_addr(fuse_addr),
        .fuse_req (fuse_req),
        .fuse_rdy (fuse_rdy),
        .fuse_word(fuse_word),
        .out_valid(out_valid),
        .out_data (out_data),
        .byte_ok  (rd_byte_ok),
        .timeout  (rd_timeout)
    );

    assign pwr_unlock = ctl.unlock;
    assign pwr_sw1    = ctl.sw1;
    assign pwr_sw2    = ctl.sw2;
    assign pwr_iso    = ctl.iso;

    AST_REQ_ONLY_POWERED: assert property (@(posedge clk) disable iff (rst)
        fuse_req |-> (pwr_sw2 && !pwr_iso)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_IDLE_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !pwr_unlock && pwr_iso)); // R8
    AST_ZERO_LEN_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !busy && (cmd_len == '0)) |=> (done && !err_busy && !pwr_unlock && !fuse_req)); // R7
    AST_NO_BYTE_WHILE_ERR: assert property (@(posedge clk) disable iff (rst)
        (busy && err_busy) |-> !out_valid); // R6

endmodule

// File: tb/test_fuse_rd_seq.sv
module test_fuse_rd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 11;
    localparam int LEN_W      = 12;
    localparam int WORD_W     = 32;
    localparam int SETTLE     = 5;
    localparam int TMO        = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              cmd_start;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LEN_W-1:0]  cmd_len;
    logic              busy;
    logic [ADDR_W-1:0] fuse_addr;
    logic              fuse_req;
    logic              fuse_rdy;
    logic [WORD_W-1:0] fuse_word;
    logic              pwr_unlock, pwr_sw1, pwr_sw2, pwr_iso;
    logic              out_valid;
    logic [7:0]        out_data;
    logic              done;
    logic              err_busy;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    fuse_rd_seq #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_W(WORD_W),
        .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)
    ) i_fuse_rd_seq (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .busy(busy), .fuse_addr(fuse_addr), .fuse_req(fuse_req), .fuse_rdy(fuse_rdy),
        .fuse_word(fuse_word), .pwr_unlock(pwr_unlock), .pwr_sw1(pwr_sw1), .pwr_sw2(pwr_sw2),
        .pwr_iso(pwr_iso), .out_valid(out_valid), .out_data(out_data), .done(done),
        .err_busy(err_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] exp_byte(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    // ---------------- fuse macro model ----------------
    int lat_cfg    = 2;
    int hang_after = -1;   // serve this many reads of the command, then go silent
    int serve_base = 0;
    int served     = 0;
    int mcnt       = 0;
    logic req_q    = 1'b0;
    int req_addrs[$];

    always @(posedge clk) begin
        if (rst) begin
            fuse_rdy  <= 1'b0;
            fuse_word <= '0;
            mcnt      <= 0;
            req_q     <= 1'b0;
        end else begin
            req_q <= fuse_req;
            if (fuse_req && !req_q) req_addrs.push_back(int'(fuse_addr));
            if (!fuse_req) begin
                fuse_rdy <= 1'b0;
                mcnt     <= 0;
            end else if (!fuse_rdy) begin
                if (hang_after >= 0 && (served - serve_base) >= hang_after) begin
                    mcnt <= mcnt;
                end else if (mcnt == lat_cfg) begin
                    fuse_rdy  <= 1'b1;
                    fuse_word <= {24'hA5C3E1 ^ 24'(fuse_addr), exp_byte(int'(fuse_addr))};
                    served    <= served + 1;
                end else begin
                    mcnt <= mcnt + 1;
                end
            end
        end
    end

    // ---------------- monitor ----------------
    // event codes: 1 unlock up, 2 sw1 up, 3 sw2 up, 4 iso off, 5 iso on, 6 sw2 down, 7 sw1 down, 8 unlock down
    int   ev_code[$];
    int   ev_cyc[$];
    int   bytes[$];
    int   done_cnt    = 0;
    int   req_in_iso  = 0;
    logic p_unl = 1'b0, p_s1 = 1'b0, p_s2 = 1'b0, p_iso = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (pwr_unlock && !p_unl) begin ev_code.push_back(1); ev_cyc.push_back(cyc); end
            if (pwr_sw1 && !p_s1)     begin ev_code.push_back(2); ev_cyc.push_back(cyc); end
            if (pwr_sw2 && !p_s2)     begin ev_code.push_back(3); ev_cyc.push_back(cyc); end
            if (!pwr_iso && p_iso)    begin ev_code.push_back(4); ev_cyc.push_back(cyc); end
            if (pwr_iso && !p_iso)    begin ev_code.push_back(5); ev_cyc.push_back(cyc); end
            if (!pwr_sw2 && p_s2)     begin ev_code.push_back(6); ev_cyc.push_back(cyc); end
            if (!pwr_sw1 && p_s1)     begin ev_code.push_back(7); ev_cyc.push_back(cyc); end
            if (!pwr_unlock && p_unl) begin ev_code.push_back(8); ev_cyc.push_back(cyc); end
            if (out_valid) bytes.push_back(int'(out_data));
            if (done) done_cnt++;
            if (fuse_req && pwr_iso) req_in_iso++;
        end
        p_unl = pwr_unlock; p_s1 = pwr_sw1; p_s2 = pwr_sw2; p_iso = pwr_iso;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    int b_ev, b_by, b_rq, b_dn, done_cyc, start_cyc;

    task automatic snap();
        b_ev = ev_code.size(); b_by = bytes.size(); b_rq = req_addrs.size();
        b_dn = done_cnt; serve_base = served;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 4000) begin @(negedge clk); n++; end
        chk(done == 1'b1, "R8", "done seen before limit", done, 1);
        done_cyc = cyc;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_cmd(input int a, input int len);
        snap();
        @(negedge clk);
        cmd_start = 1'b1; cmd_addr = ADDR_W'(a); cmd_len = LEN_W'(len);
        start_cyc = cyc;
        @(negedge clk);
        cmd_start = 1'b0;
        wait_done();
    endtask

    // checks shared by every command that powers the domain
    task automatic check_op(input string tag, input int a, input int n_bytes,
                            input int n_reqs, input bit exp_err);
        chk(ev_code.size() - b_ev == 8, "R1", {tag, " power event count"}, ev_code.size() - b_ev, 8);
        if (ev_code.size() - b_ev == 8) begin
            for (int i = 0; i < 8; i++)
                chk(ev_code[b_ev+i] == i + 1, (i < 4) ? "R1" : "R2", {tag, " power step order"},
                    ev_code[b_ev+i], i + 1);
            for (int i = 1; i < 8; i++)
                chk(ev_cyc[b_ev+i] > ev_cyc[b_ev+i-1], "R2", {tag, " one step per cycle"},
                    ev_cyc[b_ev+i] - ev_cyc[b_ev+i-1], 1);
            chk(ev_cyc[b_ev+2] - ev_cyc[b_ev+1] == SETTLE, "R1", {tag, " settle sw1->sw2"},
                ev_cyc[b_ev+2] - ev_cyc[b_ev+1], SETTLE);
            chk(ev_cyc[b_ev+6] - ev_cyc[b_ev+5] == SETTLE, "R2", {tag, " settle sw2->sw1"},
                ev_cyc[b_ev+6] - ev_cyc[b_ev+5], SETTLE);
            chk(done_cyc == ev_cyc[b_ev+7] + 1, "R8", {tag, " done after unlock drop"},
                done_cyc, ev_cyc[b_ev+7] + 1);
        end
        chk(done_cnt - b_dn == 1, "R8", {tag, " single done"}, done_cnt - b_dn, 1);
        chk(err_busy == exp_err, "R6", {tag, " err_busy"}, err_busy, exp_err);
        chk(bytes.size() - b_by == n_bytes, "R4", {tag, " byte count"}, bytes.size() - b_by, n_bytes);
        chk(req_addrs.size() - b_rq == n_reqs, "R5", {tag, " request count"},
            req_addrs.size() - b_rq, n_reqs);
        for (int i = 0; i < n_bytes && b_by + i < bytes.size(); i++)
            chk(bytes[b_by+i] == int'(exp_byte(a + i)), "R4", {tag, " byte value"},
                bytes[b_by+i], exp_byte(a + i));
        for (int i = 0; i < n_reqs && b_rq + i < req_addrs.size(); i++)
            chk(req_addrs[b_rq+i] == ((a + i) % (1 << ADDR_W)), "R5", {tag, " address order"},
                req_addrs[b_rq+i], (a + i) % (1 << ADDR_W));
        chk(req_in_iso == 0, "R3", {tag, " request while isolated"}, req_in_iso, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(pwr_iso == 1'b1, "R10", "iso after reset", pwr_iso, 1);
        chk({pwr_unlock, pwr_sw1, pwr_sw2} == 3'b000, "R10", "switches after reset",
            {pwr_unlock, pwr_sw1, pwr_sw2}, 0);
        chk({busy, fuse_req, out_valid, done, err_busy} == 5'b0, "R10", "status after reset",
            {busy, fuse_req, out_valid, done, err_busy}, 0);
    endtask

    task automatic t_basic();
        lat_cfg = 2; hang_after = -1;
        run_cmd(16, 4);
        check_op("basic", 16, 4, 4, 1'b0);
    endtask

    task automatic t_wrap_fast();
        lat_cfg = 0; hang_after = -1;
        run_cmd(2040, 9);   // crosses the top of the address space
        check_op("wrap", 2040, 9, 9, 1'b0);
    endtask

    task automatic t_latency_limit();
        lat_cfg = TMO - 2; hang_after = -1;   // ready lands in the last accepted wait cycle
        run_cmd(100, 2);
        check_op("lat_edge", 100, 2, 2, 1'b0);
    endtask

    task automatic t_timeout_first();
        lat_cfg = TMO - 1; hang_after = -1;   // one cycle too late
        run_cmd(200, 3);
        check_op("timeout", 200, 0, 1, 1'b1);
    endtask

    task automatic t_hang_mid();
        lat_cfg = 1; hang_after = 2;
        run_cmd(300, 5);
        check_op("hang_mid", 300, 2, 3, 1'b1);
        hang_after = -1;
    endtask

    task automatic t_zero_len();
        lat_cfg = 1;
        run_cmd(50, 0);
        chk(done_cyc == start_cyc + 1, "R7", "zero length done timing", done_cyc, start_cyc + 1);
        chk(ev_code.size() == b_ev, "R7", "zero length power events", ev_code.size() - b_ev, 0);
        chk(req_addrs.size() == b_rq, "R7", "zero length requests", req_addrs.size() - b_rq, 0);
        chk(err_busy == 1'b0, "R7", "zero length clears error", err_busy, 0);
        chk(done_cnt - b_dn == 1, "R8", "zero length single done", done_cnt - b_dn, 1);
    endtask

    task automatic t_start_while_busy();
        lat_cfg = 3; hang_after = -1;
        snap();
        @(negedge clk);
        cmd_start = 1'b1; cmd_addr = ADDR_W'(500); cmd_len = LEN_W'(6);
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy == 1'b1, "R9", "busy mid command", busy, 1);
        cmd_start = 1'b1; cmd_addr = ADDR_W'(900); cmd_len = LEN_W'(1);
        @(negedge clk);
        cmd_start = 1'b0;
        wait_done();
        repeat (30) @(negedge clk);
        check_op("busy_start", 500, 6, 6, 1'b0);
        chk(busy == 1'b0, "R9", "idle after ignored start", busy, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        rst = 1'b1; cmd_start = 1'b0; cmd_addr = '0; cmd_len = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap_fast();
        t_latency_limit();
        t_timeout_first();
        t_zero_len();
        t_hang_mid();
        t_start_while_busy();
        finish_run();
    end

endmodule